// File: doc/BRIEF.md
# Bitwise Compute Memory Compartment

This block is a small SRAM-style compartment that works either as an ordinary word memory or as a bank of bitwise logic units. It holds several blocks, and each block holds a number of 16-bit rows. In memory use, a word is written into, or read out of, a chosen row of a chosen block. In compute use, one stored word is combined, bit by bit, with a two-bit input vector. Input bit 0 drives the upper half of the columns and input bit 1 drives the lower half. The result of AND, OR or XOR can be inverted, and it is captured in a 16-bit result register.

All blocks drive one shared set of 16 result lines, and only the selected block places its data on them. Precharge, sensing and timing margins are reduced to one clocked evaluation. Requests have a fixed priority: a write comes first, then a read, then a compute. A compute request that cannot be served leaves a zero result and raises an error flag.

Top module: `bitcmp_compartment`

## Requirements
- R1: After reset, `rdata_o`, `res_o` and `err_o` are zero, and every stored row reads as zero.
- R2: With `wr_en_i` high, `wdata_i` is stored at (`blk_sel_i`, `row_i`). A read with `rd_en_i` high and `wr_en_i` low shows the stored word on `rdata_o` after the next rising edge. `rdata_o` holds its value in every other cycle.
- R3: A compute (`cmp_en_i` high, `wr_en_i` and `rd_en_i` low, valid block, valid operation) loads `res_o` one edge later. For result bits 15..8 the operand is `vin_i[0]`, and for bits 7..0 it is `vin_i[1]`. Each bit is combined with the same bit of the selected word by the code on `op_i`: 2'b00 gives AND, 2'b01 gives OR, 2'b10 gives XOR. A valid compute clears `err_o`.
- R4: With `inv_i` high, a valid compute stores the bitwise complement of the R3 result.
- R5: Only the selected block drives the shared lines, so the contents of other blocks have no effect on `res_o` or `rdata_o`.
- R6: A block select of `N_BLOCKS` or more is out of range. A compute with it gives `res_o` = 0 and `err_o` = 1. A write with it changes no stored word, and a read with it returns zero.
- R7: The operation code 2'b11 is reserved. A compute with it gives `res_o` = 0 and `err_o` = 1.
- R8: When `wr_en_i` and `cmp_en_i` are both high, the write takes place while `res_o` and `err_o` hold their values.
- R9: When `rd_en_i` and `cmp_en_i` are both high and `wr_en_i` is low, the read is served while `res_o` and `err_o` hold their values.
- R10: With `cmp_en_i` low, `res_o` and `err_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Memory write request |
| rd_en_i | input | 1 | Memory read request |
| cmp_en_i | input | 1 | Compute request |
| blk_sel_i | input | SEL_W (3) | Block select; values of N_BLOCKS and above are out of range |
| row_i | input | ROW_W (4) | Row address inside the block |
| wdata_i | input | 16 | Write data |
| vin_i | input | 2 | Input vector; bit 0 serves the upper columns, bit 1 the lower columns |
| op_i | input | 2 | 00 AND, 01 OR, 10 XOR, 11 reserved |
| inv_i | input | 1 | Invert the compute result |
| rdata_o | output | 16 | Registered read data |
| res_o | output | 16 | Registered compute result |
| err_o | output | 1 | Error flag from the last compute that was served |

## Verification
Compute is tried with all four values of `vin_i`, crossed with every operation and both invert settings. This shows whether each column half follows its own input bit, or whether the halves are swapped or tied together. The stored words used as operands are asymmetric, such as 16'hA5C3, so that an exchange of the upper and lower halves changes the result. The same row address is filled with different words in different blocks, which catches a wrong block reaching the shared lines. Random traffic, including out-of-range blocks, the reserved operation code and colliding requests, is compared against a shadow copy of the memory to test the request priority.

// File: rtl/bitcmp_pkg.sv
package bitcmp_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_XOR = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  // one column's logic between its driven input bit and its stored bit
  function automatic logic col_op(op_e op, logic in_bit, logic mem_bit);
    logic y;
    case (op)
      OP_AND:  y = in_bit & mem_bit;
      OP_OR:   y = in_bit | mem_bit;
      OP_XOR:  y = in_bit ^ mem_bit;
      default: y = 1'b0;
    endcase
    return y;
  endfunction

  // value latched for a compute: zero when it cannot be served
  function automatic logic [WORD_W-1:0] finish_word(logic ok, logic inv,
                                                    logic [WORD_W-1:0] raw);
    logic [WORD_W-1:0] y;
    if (!ok)      y = '0;
    else if (inv) y = ~raw;
    else          y = raw;
    return y;
  endfunction
endpackage

// File: rtl/bitcmp_input_map.sv
module bitcmp_input_map
  import bitcmp_pkg::*;
(
  input  logic [1:0]        vin_i,
  output logic [WORD_W-1:0] line_o
);
  // upper half of the columns is fed by vin_i[0], lower half by vin_i[1]
  for (genvar c = 0; c < WORD_W; c++) begin : g_col
    if (c >= HALF_W) begin : g_hi
      assign line_o[c] = vin_i[0];
    end else begin : g_lo
      assign line_o[c] = vin_i[1];
    end
  end
endmodule

// File: rtl/bitcmp_lpu.sv
module bitcmp_lpu
  import bitcmp_pkg::*;
(
  input  op_e               op_i,
  input  logic [WORD_W-1:0] line_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] y_o
);
  for (genvar c = 0; c < WORD_W; c++) begin : g_unit
    assign y_o[c] = col_op(op_i, line_i[c], word_i[c]);
  end
endmodule

// File: rtl/bitcmp_block.sv
module bitcmp_block
  import bitcmp_pkg::*;
#(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned ROW_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              drive_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] line_i,
  input  op_e               op_i,
  output logic [WORD_W-1:0] bl_o,
  output logic [WORD_W-1:0] cl_o
);
  logic [WORD_W-1:0] cells [ROWS];
  logic [WORD_W-1:0] picked;
  logic [WORD_W-1:0] lpu_y;
  logic              row_ok;

  assign row_ok = (32'(row_i) < ROWS);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else if (we_i && row_ok) begin
      cells[row_i] <= wdata_i;
    end
  end

  assign picked = row_ok ? cells[row_i] : '0;

  bitcmp_lpu lpu_i (
    .op_i   (op_i),
    .line_i (line_i),
    .word_i (picked),
    .y_o    (lpu_y)
  );

  // a block puts data on the shared lines only while it is driving
  assign bl_o = drive_i ? picked : '0;
  assign cl_o = drive_i ? lpu_y  : '0;
endmodule

// File: rtl/bitcmp_sense.sv
module bitcmp_sense
  import bitcmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_fire_i,
  input  logic              cmp_fire_i,
  input  logic              cmp_ok_i,
  input  logic              inv_i,
  input  logic [WORD_W-1:0] bl_i,
  input  logic [WORD_W-1:0] cl_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WORD_W-1:0] res_o,
  output logic              err_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      res_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd_fire_i) rdata_o <= bl_i;
      if (cmp_fire_i) begin
        res_o <= finish_word(cmp_ok_i, inv_i, cl_i);
        err_o <= !cmp_ok_i;
      end
    end
  end
endmodule

// File: rtl/bitcmp_compartment.sv
module bitcmp_compartment
  import bitcmp_pkg::*;
#(
  parameter int unsigned N_BLOCKS = 4,
  parameter int unsigned ROWS     = 16,
  parameter int unsigned SEL_W    = $clog2(N_BLOCKS) + 1,
  parameter int unsigned ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              cmp_en_i,
  input  logic [SEL_W-1:0]  blk_sel_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        vin_i,
  input  logic [1:0]        op_i,
  input  logic              inv_i,
  output logic [15:0]       rdata_o,
  output logic [15:0]       res_o,
  output logic              err_o
);
  op_e                op;
  logic               blk_ok;
  logic               op_ok;
  logic               rd_fire;
  logic               cmp_fire;
  logic [N_BLOCKS-1:0] blk_drive;
  logic [N_BLOCKS-1:0] blk_we;
  logic [WORD_W-1:0]  in_lines;
  logic [WORD_W-1:0]  bl_w [N_BLOCKS];
  logic [WORD_W-1:0]  cl_w [N_BLOCKS];
  logic [WORD_W-1:0]  bl_bus;
  logic [WORD_W-1:0]  cl_bus;

  assign op     = op_e'(op_i);
  assign blk_ok = (32'(blk_sel_i) < N_BLOCKS);
  assign op_ok  = (op != OP_RSV);

  // priority: write, then read, then compute
  assign rd_fire  = rd_en_i && !wr_en_i;
  assign cmp_fire = cmp_en_i && !wr_en_i && !rd_en_i;

  bitcmp_input_map map_i (
    .vin_i  (vin_i),
    .line_o (in_lines)
  );

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_blk
    assign blk_we[b]    = wr_en_i && (blk_sel_i == SEL_W'(b));
    assign blk_drive[b] = (rd_fire || cmp_fire) && (blk_sel_i == SEL_W'(b));

    bitcmp_block #(
      .ROWS  (ROWS),
      .ROW_W (ROW_W)
    ) blk_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (blk_we[b]),
      .drive_i (blk_drive[b]),
      .row_i   (row_i),
      .wdata_i (wdata_i),
      .line_i  (in_lines),
      .op_i    (op),
      .bl_o    (bl_w[b]),
      .cl_o    (cl_w[b])
    );
  end

  // shared lines: wired-OR of the gated block outputs
  always_comb begin
    bl_bus = '0;
    cl_bus = '0;
    for (int b = 0; b < N_BLOCKS; b++) begin
      bl_bus = bl_bus | bl_w[b];
      cl_bus = cl_bus | cl_w[b];
    end
  end

  bitcmp_sense sense_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_fire_i  (rd_fire),
    .cmp_fire_i (cmp_fire),
    .cmp_ok_i   (blk_ok && op_ok),
    .inv_i      (inv_i),
    .bl_i       (bl_bus),
    .cl_i       (cl_bus),
    .rdata_o    (rdata_o),
    .res_o      (res_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/bitcmp_checker.sv
module bitcmp_checker #(
  parameter int unsigned N_BLOCKS = 4,
  parameter int unsigned SEL_W    = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic                cmp_en_i,
  input logic [SEL_W-1:0]    blk_sel_i,
  input logic [1:0]          vin_i,
  input logic [1:0]          op_i,
  input logic                inv_i,
  input logic [15:0]         rdata_o,
  input logic [15:0]         res_o,
  input logic                err_o,
  input logic [N_BLOCKS-1:0] blk_drive,
  input logic                cmp_fire
);
  logic sel_in;
  assign sel_in = (32'(blk_sel_i) < N_BLOCKS);

  a_r5_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(blk_drive));

  a_r5_driver_on_compute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_fire && sel_in) |-> ($countones(blk_drive) == 1));

  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i || wr_en_i) |=> $stable(rdata_o));

  a_r3_and_zero_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && !wr_en_i && !rd_en_i && sel_in && op_i == 2'b00 &&
     vin_i == 2'b00 && !inv_i) |=> (res_o == 16'h0000 && !err_o));

  a_r6_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && !wr_en_i && !rd_en_i && !sel_in) |=> (res_o == 16'h0000 && err_o));

  a_r7_reserved_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && !wr_en_i && !rd_en_i && op_i == 2'b11) |=> (res_o == 16'h0000 && err_o));

  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ($stable(res_o) && $stable(err_o)));

  a_r9_read_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> ($stable(res_o) && $stable(err_o)));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_i |=> ($stable(res_o) && $stable(err_o)));
endmodule

bind bitcmp_compartment bitcmp_checker #(
  .N_BLOCKS (N_BLOCKS),
  .SEL_W    (SEL_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .cmp_en_i  (cmp_en_i),
  .blk_sel_i (blk_sel_i),
  .vin_i     (vin_i),
  .op_i      (op_i),
  .inv_i     (inv_i),
  .rdata_o   (rdata_o),
  .res_o     (res_o),
  .err_o     (err_o),
  .blk_drive (blk_drive),
  .cmp_fire  (cmp_fire)
);

// File: tb/bitcmp_compartment_tb_top.sv
module bitcmp_compartment_tb_top;
  localparam int NB = 4;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0, cmp_en_i = 1'b0, inv_i = 1'b0;
  logic [2:0]  blk_sel_i = '0;
  logic [3:0]  row_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  vin_i = '0, op_i = '0;
  logic [15:0] rdata_o, res_o;
  logic        err_o;

  logic [15:0] shadow [NB][NR];
  logic [15:0] m_rdata = '0, m_res = '0;
  logic        m_err = 1'b0;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  bitcmp_compartment dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .cmp_en_i(cmp_en_i), .blk_sel_i(blk_sel_i), .row_i(row_i),
    .wdata_i(wdata_i), .vin_i(vin_i), .op_i(op_i), .inv_i(inv_i),
    .rdata_o(rdata_o), .res_o(res_o), .err_o(err_o)
  );

  // independent restatement: walk the bits, choose operand by column half
  function automatic logic [15:0] ref_res(logic [15:0] w, logic [1:0] v,
                                          logic [1:0] op, logic inv);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      logic a;
      a = (i < 8) ? v[1] : v[0];
      if (op == 2'd0)      r[i] = a && w[i];
      else if (op == 2'd1) r[i] = a || w[i];
      else                 r[i] = (a != w[i]);
    end
    return inv ? ~r : r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic re,
                      input logic ce, input int blk, input int row,
                      input logic [15:0] wd, input logic [1:0] vin,
                      input logic [1:0] op, input logic inv);
    wr_en_i = we; rd_en_i = re; cmp_en_i = ce;
    blk_sel_i = 3'(blk); row_i = 4'(row); wdata_i = wd;
    vin_i = vin; op_i = op; inv_i = inv;
    if (we) begin
      if (blk < NB) shadow[blk][row] = wd;
    end else if (re) begin
      m_rdata = (blk < NB) ? shadow[blk][row] : 16'h0000;
    end else if (ce) begin
      if (blk >= NB || op == 2'd3) begin
        m_res = 16'h0000; m_err = 1'b1;
      end else begin
        m_res = ref_res(shadow[blk][row], vin, op, inv); m_err = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0; cmp_en_i = 1'b0;
    chk(tag, "rdata", rdata_o, m_rdata);
    chk(tag, "res", res_o, m_res);
    chk(tag, "err", {15'd0, err_o}, {15'd0, m_err});
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7411));
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) shadow[b][r] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state and cleared storage
    chk("R1", "rdata", rdata_o, 16'h0000);
    chk("R1", "res", res_o, 16'h0000);
    chk("R1", "err", {15'd0, err_o}, 16'h0000);
    step("R1", 0, 1, 0, 2, 9, 16'h0, 2'b0, 2'b0, 0);
    // R2: fill and read back
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++)
        step("R2", 1, 0, 0, b, r, 16'($urandom), 2'b0, 2'b0, 0);
    for (int k = 0; k < 8; k++)
      step("R2", 0, 1, 0, k % NB, (k * 5) % NR, 16'h0, 2'b0, 2'b0, 0);
    step("R2", 0, 0, 0, 0, 0, 16'h0, 2'b0, 2'b0, 0);
    // R3 / R4: asymmetric word against every vin, op and invert
    step("R3", 1, 0, 0, 1, 3, 16'hA5C3, 2'b0, 2'b0, 0);
    for (int v = 0; v < 4; v++)
      for (int o = 0; o < 3; o++) begin
        step("R3", 0, 0, 1, 1, 3, 16'h0, 2'(v), 2'(o), 0);
        step("R4", 0, 0, 1, 1, 3, 16'h0, 2'(v), 2'(o), 1);
      end
    // R5: same row, distinct contents per block
    for (int b = 0; b < NB; b++)
      step("R5", 1, 0, 0, b, 7, 16'h1111 << b, 2'b0, 2'b0, 0);
    for (int b = 0; b < NB; b++) begin
      step("R5", 0, 0, 1, b, 7, 16'h0, 2'b01, 2'd2, 0);
      step("R5", 0, 1, 0, b, 7, 16'h0, 2'b0, 2'b0, 0);
    end
    // R6: out-of-range block
    step("R6", 0, 0, 1, 4, 7, 16'h0, 2'b11, 2'd1, 1);
    step("R6", 1, 0, 0, 5, 7, 16'hDEAD, 2'b0, 2'b0, 0);
    step("R6", 0, 1, 0, 5, 7, 16'h0, 2'b0, 2'b0, 0);
    for (int b = 0; b < NB; b++)
      step("R6", 0, 1, 0, b, 7, 16'h0, 2'b0, 2'b0, 0);
    // R7: reserved code, then a valid compute clears the flag
    step("R7", 0, 0, 1, 2, 7, 16'h0, 2'b11, 2'd3, 0);
    step("R7", 0, 0, 1, 2, 7, 16'h0, 2'b11, 2'd0, 0);
    // R8: write and compute together
    step("R8", 1, 0, 1, 0, 2, 16'h3C5A, 2'b10, 2'd1, 1);
    step("R8", 0, 1, 0, 0, 2, 16'h0, 2'b0, 2'b0, 0);
    // R9: read and compute together
    step("R9", 0, 1, 1, 1, 3, 16'h0, 2'b01, 2'd2, 0);
    // R10: idle cycles hold the result
    step("R10", 0, 0, 0, 3, 0, 16'hFFFF, 2'b11, 2'd1, 1);
    step("R10", 0, 0, 0, 6, 1, 16'h0, 2'b01, 2'd3, 0);
    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int kind = int'($urandom_range(0, 9));
      step("R3", kind < 2, kind == 2 || kind == 9, kind >= 3,
           int'($urandom_range(0, 5)), int'($urandom_range(0, NR - 1)),
           16'($urandom), 2'($urandom), 2'($urandom_range(0, 3)), 1'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule